// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces memory addresses for indirect accesses. An access names an index register and a modify register. The current index goes out as the address in the same cycle. On the following clock edge the index is post-modified by the selected modify value. When the set has a non-zero length, the updated index is folded back into the window from base to base plus length. That window may begin at any address and may have any size. No alignment or power-of-two restriction applies.

Two copies of the register state are held: a primary bank and a secondary bank. Each bank has sixteen sets, and each set holds an index, a modify, a length and a base register. A single bank-select input chooses which bank serves both accesses and writes. Switching keeps the contents of both banks, so a context switch costs one cycle. A system that needs two addresses per cycle instantiates the block twice, one per data bus.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset every register in both banks is zero and the primary bank is active. An access then returns address 0.
- R2: The address output equals the selected index register of the active bank in the cycle `acc_en_i` is high, and is zero while `acc_en_i` is low.
- R3: When the selected set's length is zero, an access updates its index to index + modify, modulo 2^32. The modify value is a two's-complement number.
- R4: When length is non-zero and index + modify is at or above base + length, the new index is index + modify − length.
- R5: When length is non-zero and index + modify is below base, the new index is index + modify + length. For an index inside the window and |modify| ≤ length, the result stays inside the window.
- R6: The register kind code `wr_kind_i` selects the target register: 0 index, 1 modify, 2 length, 3 base. Writing a base (code 3) also loads the same set's index with the written value.
- R7: A change on `bank_sel_i` (0 primary, 1 secondary) affects accesses and writes from the next cycle on. The other bank keeps its contents.
- R8: If a write to a set's index or base coincides with an access to that set's index, the written value wins.
- R9: Cycles with no access and no write leave all index registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Target register kind (0 index, 1 modify, 2 length, 3 base) |
| wr_sel_i | input | 4 | Register set number for the write |
| wr_data_i | input | 32 | Write data |
| acc_en_i | input | 1 | Access request |
| acc_isel_i | input | 4 | Set supplying index, base and length |
| acc_msel_i | input | 4 | Set supplying the modify value |
| bank_sel_i | input | 1 | Bank choice, 0 primary, 1 secondary |
| addr_o | output | 32 | Address of the current access |

## Verification
The bench drives a buffer that starts at an odd, unaligned address. It then steps forward and backward across both ends of the window; a wrong comparison bound would skip to base + length or leave the window. Negative modifies are run through address zero in linear mode, where a design that treats modify as unsigned or applies a wrap at length zero returns a wrong address. The bench also flips the bank in the same cycle as an access, which catches a design that switches too early. It writes an index while accessing the same set, which catches a design that lets the post-modify win. A random phase then mixes writes, accesses and bank changes against the reference model.

// File: rtl/cag_pkg.sv
package cag_pkg;
  typedef enum logic [1:0] {
    REG_IDX  = 2'd0,
    REG_MOD  = 2'd1,
    REG_LEN  = 2'd2,
    REG_BASE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/cag_post_mod.sv
module cag_post_mod #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] idx_i,
  input  logic [DATA_W-1:0] mod_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] len_i,
  output logic [DATA_W-1:0] nxt_o
);
  localparam int EXT_W = DATA_W + 2;

  logic signed [EXT_W-1:0] sum, lo, hi, len_x, res;

  always_comb begin
    sum   = $signed({2'b00, idx_i}) + $signed({{2{mod_i[DATA_W-1]}}, mod_i});
    lo    = $signed({2'b00, base_i});
    len_x = $signed({2'b00, len_i});
    hi    = lo + len_x;
    if (sum >= hi)     res = sum - len_x;
    else if (sum < lo) res = sum + len_x;
    else               res = sum;
    // zero length: plain linear post-modify
    if (len_i == '0) nxt_o = idx_i + mod_i;
    else             nxt_o = res[DATA_W-1:0];
  end
endmodule

// File: rtl/cag_bank.sv
module cag_bank
  import cag_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_SETS = 16,
  parameter int SEL_W    = $clog2(NUM_SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_kind_e         wr_kind_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              upd_en_i,
  input  logic [SEL_W-1:0]  upd_sel_i,
  input  logic [DATA_W-1:0] upd_data_i,
  input  logic [SEL_W-1:0]  rd_isel_i,
  input  logic [SEL_W-1:0]  rd_msel_i,
  output logic [DATA_W-1:0] idx_o,
  output logic [DATA_W-1:0] mod_o,
  output logic [DATA_W-1:0] len_o,
  output logic [DATA_W-1:0] base_o
);
  logic [DATA_W-1:0] idx_q  [NUM_SETS];
  logic [DATA_W-1:0] mod_q  [NUM_SETS];
  logic [DATA_W-1:0] len_q  [NUM_SETS];
  logic [DATA_W-1:0] base_q [NUM_SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        idx_q[s]  <= '0;
        mod_q[s]  <= '0;
        len_q[s]  <= '0;
        base_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NUM_SETS; s++) begin
        if (wr_en_i && wr_sel_i == SEL_W'(s)) begin
          unique case (wr_kind_i)
            REG_MOD:  mod_q[s]  <= wr_data_i;
            REG_LEN:  len_q[s]  <= wr_data_i;
            REG_BASE: base_q[s] <= wr_data_i;
            default:  ;
          endcase
        end
        // write beats post-modify on the same index
        if (wr_en_i && wr_sel_i == SEL_W'(s) &&
            (wr_kind_i == REG_IDX || wr_kind_i == REG_BASE))
          idx_q[s] <= wr_data_i;
        else if (upd_en_i && upd_sel_i == SEL_W'(s))
          idx_q[s] <= upd_data_i;
      end
    end
  end

  assign idx_o  = idx_q[rd_isel_i];
  assign len_o  = len_q[rd_isel_i];
  assign base_o = base_q[rd_isel_i];
  assign mod_o  = mod_q[rd_msel_i];
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import cag_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_SETS = 16,
  parameter int SEL_W    = $clog2(NUM_SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_kind_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              acc_en_i,
  input  logic [SEL_W-1:0]  acc_isel_i,
  input  logic [SEL_W-1:0]  acc_msel_i,
  input  logic              bank_sel_i,
  output logic [DATA_W-1:0] addr_o
);
  localparam int NUM_BANKS = 2;

  logic              bank_q;
  logic [DATA_W-1:0] bk_idx  [NUM_BANKS];
  logic [DATA_W-1:0] bk_mod  [NUM_BANKS];
  logic [DATA_W-1:0] bk_len  [NUM_BANKS];
  logic [DATA_W-1:0] bk_base [NUM_BANKS];
  logic [DATA_W-1:0] cur_idx, cur_mod, cur_len, cur_base, nxt_idx;
  reg_kind_e         wr_kind;

  assign wr_kind = reg_kind_e'(wr_kind_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_q <= 1'b0;
    else         bank_q <= bank_sel_i;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic act;
    assign act = (bank_q == b[0]);
    cag_bank #(.DATA_W(DATA_W), .NUM_SETS(NUM_SETS), .SEL_W(SEL_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i & act),
      .wr_kind_i  (wr_kind),
      .wr_sel_i   (wr_sel_i),
      .wr_data_i  (wr_data_i),
      .upd_en_i   (acc_en_i & act),
      .upd_sel_i  (acc_isel_i),
      .upd_data_i (nxt_idx),
      .rd_isel_i  (acc_isel_i),
      .rd_msel_i  (acc_msel_i),
      .idx_o      (bk_idx[b]),
      .mod_o      (bk_mod[b]),
      .len_o      (bk_len[b]),
      .base_o     (bk_base[b])
    );
  end

  assign cur_idx  = bk_idx[bank_q];
  assign cur_mod  = bk_mod[bank_q];
  assign cur_len  = bk_len[bank_q];
  assign cur_base = bk_base[bank_q];

  cag_post_mod #(.DATA_W(DATA_W)) u_post_mod (
    .idx_i  (cur_idx),
    .mod_i  (cur_mod),
    .base_i (cur_base),
    .len_i  (cur_len),
    .nxt_o  (nxt_idx)
  );

  assign addr_o = acc_en_i ? cur_idx : '0;
endmodule

// File: rtl/cag_checker.sv
module cag_checker #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_kind_i,
  input logic [SEL_W-1:0]  wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              acc_en_i,
  input logic [SEL_W-1:0]  acc_isel_i,
  input logic [DATA_W-1:0] addr_o,
  input logic              bank_sel_i,
  input logic [DATA_W-1:0] cur_mod,
  input logic [DATA_W-1:0] cur_len,
  input logic [DATA_W-1:0] cur_base
);
  logic       bsel_d1, bsel_d2;
  logic [1:0] warm;
  logic       steady;
  logic       pre_in, pre_mag_ok, post_in;
  logic [DATA_W-1:0] mag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsel_d1 <= 1'b0;
      bsel_d2 <= 1'b0;
      warm    <= '0;
    end else begin
      bsel_d1 <= bank_sel_i;
      bsel_d2 <= bsel_d1;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  function automatic logic in_win(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b,
                                  logic [DATA_W-1:0] l);
    return ({2'b00, a} >= {2'b00, b}) && ({2'b00, a} < ({2'b00, b} + {2'b00, l}));
  endfunction

  // active bank identical in this and the previous cycle
  assign steady     = (warm >= 2'd2) && (bsel_d1 == bsel_d2);
  assign mag        = cur_mod[DATA_W-1] ? (~cur_mod + 1'b1) : cur_mod;
  assign pre_in     = acc_en_i && (cur_len != '0) && in_win(addr_o, cur_base, cur_len);
  assign pre_mag_ok = (mag <= cur_len);
  assign post_in    = in_win(addr_o, cur_base, cur_len);

  assert_linear_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && $past(acc_en_i) && !$past(wr_en_i) && $past(cur_len) == '0 &&
     acc_en_i && acc_isel_i == $past(acc_isel_i))
    |-> addr_o == $past(addr_o) + $past(cur_mod));

  // covers both wrap directions (R5 as well)
  assert_stays_in_buffer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && $past(pre_in) && $past(pre_mag_ok) && !$past(wr_en_i) &&
     acc_en_i && acc_isel_i == $past(acc_isel_i))
    |-> post_in);

  assert_base_loads_index_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && $past(wr_en_i) && $past(wr_kind_i) == 2'd3 &&
     acc_en_i && acc_isel_i == $past(wr_sel_i))
    |-> addr_o == $past(wr_data_i));

  assert_write_beats_update_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && $past(wr_en_i) && $past(wr_kind_i) == 2'd0 && $past(acc_en_i) &&
     $past(acc_isel_i) == $past(wr_sel_i) && acc_en_i && acc_isel_i == $past(acc_isel_i))
    |-> addr_o == $past(wr_data_i));
endmodule

bind circ_addr_gen cag_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_cag_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_kind_i  (wr_kind_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .acc_en_i   (acc_en_i),
  .acc_isel_i (acc_isel_i),
  .addr_o     (addr_o),
  .bank_sel_i (bank_sel_i),
  .cur_mod    (cur_mod),
  .cur_len    (cur_len),
  .cur_base   (cur_base)
);

// File: tb/tb_circ_addr_gen.sv
module tb_circ_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_kind_i = '0;
  logic [3:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        acc_en_i = 1'b0;
  logic [3:0]  acc_isel_i = '0;
  logic [3:0]  acc_msel_i = '0;
  logic        bank_sel_i = 1'b0;
  logic [31:0] addr_o;

  int    n_vec = 0;
  int    n_bad = 0;
  string req = "R1";

  logic [31:0] m_idx [2][16];
  logic [31:0] m_mod [2][16];
  logic [31:0] m_len [2][16];
  logic [31:0] m_base[2][16];
  int          m_bank;

  circ_addr_gen dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] step_ref(logic [31:0] i, logic [31:0] m,
                                           logic [31:0] b, logic [31:0] l);
    longint s;
    if (l == 0) return i + m;
    s = longint'(i) + longint'($signed(m));
    if (s >= longint'(b) + longint'(l)) s = s - longint'(l);
    else if (s < longint'(b))           s = s + longint'(l);
    return s[31:0];
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 16; s++) begin
        m_idx[b][s] = '0; m_mod[b][s] = '0; m_len[b][s] = '0; m_base[b][s] = '0;
      end
    m_bank = 0;
  endtask

  task automatic cycle();
    logic [31:0] exp;
    @(negedge clk_i);
    exp = acc_en_i ? m_idx[m_bank][acc_isel_i] : 32'd0;
    n_vec++;
    if (addr_o !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_o=%h expected %h at %0t", req, addr_o, exp, $time);
    end
    if (acc_en_i)
      m_idx[m_bank][acc_isel_i] = step_ref(m_idx[m_bank][acc_isel_i],
        m_mod[m_bank][acc_msel_i], m_base[m_bank][acc_isel_i], m_len[m_bank][acc_isel_i]);
    if (wr_en_i) begin
      case (wr_kind_i)
        2'd0: m_idx[m_bank][wr_sel_i] = wr_data_i;
        2'd1: m_mod[m_bank][wr_sel_i] = wr_data_i;
        2'd2: m_len[m_bank][wr_sel_i] = wr_data_i;
        default: begin
          m_base[m_bank][wr_sel_i] = wr_data_i;
          m_idx[m_bank][wr_sel_i]  = wr_data_i;
        end
      endcase
    end
    m_bank = int'(bank_sel_i);
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [1:0] k, input int s, input logic [31:0] d);
    wr_en_i = 1'b1; wr_kind_i = k; wr_sel_i = 4'(s); wr_data_i = d;
    cycle();
    wr_en_i = 1'b0;
  endtask

  task automatic acc(input int i, input int m);
    acc_en_i = 1'b1; acc_isel_i = 4'(i); acc_msel_i = 4'(m);
    cycle();
    acc_en_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1: reset contents in both banks
    req = "R1";
    cycle();
    acc(3, 7);
    acc(15, 0);

    // R3: linear mode, positive and negative modify, wrap through zero
    req = "R3";
    wr(2'd0, 0, 32'd100); wr(2'd1, 0, 32'd4);
    acc(0, 0); acc(0, 0); acc(0, 0);
    wr(2'd1, 1, 32'hFFFF_FFF8); wr(2'd0, 1, 32'd2);
    acc(1, 1); acc(1, 1); acc(1, 1);

    // R6: base write loads index; unaligned buffer 1003..1009
    req = "R6";
    wr(2'd2, 2, 32'd7); wr(2'd1, 2, 32'd3); wr(2'd3, 2, 32'd1003);
    acc(2, 3);
    // R4: forward wrap 1003,1006,1009 -> 1005
    req = "R4";
    acc(2, 2); acc(2, 2); acc(2, 2); acc(2, 2); acc(2, 2); acc(2, 2);
    wr(2'd1, 4, 32'd7);
    acc(2, 4); acc(2, 4);
    // R5: backward wrap with modify -5
    req = "R5";
    wr(2'd1, 3, 32'hFFFF_FFFB);
    acc(2, 3); acc(2, 3); acc(2, 3); acc(2, 3); acc(2, 3);
    wr(2'd1, 5, 32'hFFFF_FFF9);
    acc(2, 5); acc(2, 5);

    // R9: idle cycles leave indices alone
    req = "R9";
    repeat (4) cycle();
    acc(2, 7); acc(0, 7); acc(1, 7);

    // R2: no access gives zero address
    req = "R2";
    acc_isel_i = 4'd2; cycle(); cycle();

    // R7: switch lands one cycle late, banks kept apart
    req = "R7";
    bank_sel_i = 1'b1;
    acc(2, 7);
    acc(2, 7);
    wr(2'd3, 2, 32'd50); wr(2'd2, 2, 32'd5); wr(2'd1, 2, 32'd2);
    acc(2, 2); acc(2, 2); acc(2, 2);
    bank_sel_i = 1'b0;
    acc(2, 7);
    acc(2, 7);
    bank_sel_i = 1'b1;
    cycle();
    acc(2, 7);
    bank_sel_i = 1'b0;
    cycle();

    // R8: write and access to one set in the same cycle
    req = "R8";
    wr_en_i = 1'b1; wr_kind_i = 2'd0; wr_sel_i = 4'd2; wr_data_i = 32'd1008;
    acc_en_i = 1'b1; acc_isel_i = 4'd2; acc_msel_i = 4'd2;
    cycle();
    wr_en_i = 1'b0;
    wr_kind_i = 2'd3; wr_data_i = 32'd1004; wr_en_i = 1'b1;
    cycle();
    wr_en_i = 1'b0;
    acc(2, 2);

    // mixed traffic against the model (R2, R4, R5, R7)
    req = "R2";
    for (int s = 0; s < 16; s++) begin
      automatic logic [31:0] l = (s % 4 == 0) ? 32'd0 : 32'($urandom_range(1, 40));
      wr(2'd2, s, l);
      wr(2'd3, s, $urandom);
      wr(2'd1, s, 32'($signed($urandom_range(0, 80)) - 40) & ((l == 0) ? 32'hFFFF_FFFF : 32'hFFFF_FFFF));
    end
    for (int n = 0; n < 3000; n++) begin
      acc_en_i   = ($urandom_range(0, 3) != 0);
      acc_isel_i = 4'($urandom);
      acc_msel_i = 4'($urandom);
      wr_en_i    = ($urandom_range(0, 9) == 0);
      wr_kind_i  = 2'($urandom);
      wr_sel_i   = 4'($urandom);
      wr_data_i  = (wr_kind_i == 2'd2) ? 32'($urandom_range(0, 40)) :
                   (wr_kind_i == 2'd1) ? 32'($signed($urandom_range(0, 20)) - 10) : $urandom;
      if ($urandom_range(0, 15) == 0) bank_sel_i = ~bank_sel_i;
      cycle();
    end
    wr_en_i = 1'b0; acc_en_i = 1'b0;
    cycle();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule